// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that sits behind a small register interface. Software pushes outgoing bytes into a deep transmit queue, and the engine sends each one as a full-duplex 8-bit transfer. The byte captured from the slave during each transfer goes into a separate receive queue, which software drains through the same data address that it writes.

A control register sets the serial clock rate, the clock polarity and the clock phase, so any of the four SPI modes can be used. Two self-clearing command bits in that register flush either queue on its own. A status register reports both queue fill levels in one word. A single active-low chip select frames each burst of back-to-back bytes.

Register addresses: `addr`=0 is control, `addr`=1 is status, `addr`=2 is data.

Top module: `spi_qmaster`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and control, status and data all read as zero.
- R2: A control write stores the prescaler in bits [7:0], the idle clock level (polarity) in bit 8 and the phase select in bit 9. A control read returns these fields in the same positions. Bit 10 flushes the transmit queue and bit 11 flushes the receive queue. These two command bits are not stored and read back as 0.
- R3: A status read returns the transmit queue level in bits [7:0] and the receive queue level in bits [15:8]. Each field saturates at 255 when its queue holds 256 bytes.
- R4: A write to the data address appends `wdata[7:0]` to the 256-entry transmit queue. A write made while the queue is full is dropped and the byte is never sent.
- R5: A read of the data address returns the oldest received byte in bits [7:0] and removes it from the queue. When the receive queue is empty the read returns 0 and the status does not change.
- R6: Within a byte, every `sck` half-period lasts prescaler+1 clock cycles.
- R7: Bytes are shifted most significant bit first. With phase 0, `miso` is sampled and `mosi` is stable on the leading `sck` edge, and `mosi` changes on the trailing edge. With phase 1, `mosi` changes on the leading edge and sampling happens on the trailing edge. Every transmitted byte yields exactly one received byte, in order.
- R8: While `cs_n` is high, `sck` rests at the programmed polarity level.
- R9: `cs_n` falls at least one cycle before the first clock edge of a burst. It stays low while queued bytes remain, and it rises only after the last bit of the final byte, once the transmit queue is empty. One burst gives exactly one falling edge.
- R10: Flushing the transmit queue empties it at once, but the byte already in flight still completes. Flushing one queue leaves the other untouched.
- R11: A byte received while the receive queue is full is discarded, and the 256 bytes already held are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a data read pops a byte) |
| wdata | input | 12 | Write data |
| rdata | output | 16 | Read data, valid in the same cycle as `addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Active-low chip select |

## Verification
A queue pointer or count that slips shows up at the status word at once. It also shows up a burst later as a byte missing, repeated or reordered on `mosi` or in the data read-back. If the half-period counter or edge counter goes wrong, the very next `sck` edge comes at the wrong cycle, or a byte finishes with the wrong number of edges. If sample and shift edges are swapped for a mode, the first captured byte of that mode's burst comes back shifted by one bit. Chip-select sequencing errors appear as an extra falling edge, or as a clock edge while `cs_n` is still high.

// File: rtl/spi_qm_pkg.sv
`timescale 1ns/1ps
package spi_qm_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Clamp a queue level into an 8-bit status field.
  function automatic logic [7:0] sat_level(input logic [15:0] n);
    if (n > 16'd255) return 8'hFF;
    return n[7:0];
  endfunction

  // Phase 0 samples on the leading edge, phase 1 on the trailing edge.
  function automatic logic is_sample_edge(input logic leading, input logic cpha);
    return leading ^ cpha;
  endfunction

endpackage

// File: rtl/spi_qm_fifo.sv
`timescale 1ns/1ps
module spi_qm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= next_ptr(wp);
      if (do_pop)  rp <= next_ptr(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  // A push into a full queue without a pop leaves it full, never wrapping.
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && $stable(count)));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/spi_qm_engine.sv
`timescale 1ns/1ps
module spi_qm_engine #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    tx_byte,
  input  logic          cpha,
  input  logic [PW-1:0] presc,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx_byte,
  output logic          phase,
  output logic          mosi
);
  import spi_qm_pkg::*;

  localparam int EDGES = 16;
  localparam int EW    = $clog2(EDGES);

  logic [PW-1:0] hcnt, presc_l;
  logic [EW-1:0] ecnt;
  logic [7:0]    sh, rxs;
  logic          cpha_l, ph;

  // Named internal events for the checks.
  logic edge_evt, leading, sample_now, last_edge;
  assign edge_evt   = busy && (hcnt == presc_l);
  assign leading    = ~ecnt[0];
  assign sample_now = is_sample_edge(leading, cpha_l);
  assign last_edge  = (ecnt == EW'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      hcnt    <= '0;
      presc_l <= '0;
      ecnt    <= '0;
      sh      <= '0;
      rxs     <= '0;
      cpha_l  <= 1'b0;
      ph      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        hcnt    <= '0;
        ecnt    <= '0;
        ph      <= 1'b0;
        sh      <= tx_byte;
        cpha_l  <= cpha;
        presc_l <= presc;
      end else if (busy) begin
        if (edge_evt) begin
          hcnt <= '0;
          ph   <= ~ph;
          ecnt <= ecnt + 1'b1;
          if (sample_now)
            rxs <= {rxs[6:0], miso};
          else if (!(cpha_l && ecnt == '0))
            sh <= {sh[6:0], 1'b0};
          if (last_edge) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  assign phase   = ph;
  assign mosi    = sh[7];
  assign rx_byte = rxs;

  // Clock level holds between edge events.
  assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_evt && !start) |=> $stable(phase));

  // A finished byte has returned the clock to its resting phase.
  assert_byte_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !phase));

endmodule

// File: rtl/spi_qmaster.sv
`timescale 1ns/1ps
module spi_qmaster #(
  parameter int DEPTH = 256,
  parameter int PW    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] wdata,
  output logic [15:0] rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  import spi_qm_pkg::*;

  localparam int CW     = $clog2(DEPTH) + 1;
  localparam int B_CPOL = PW;
  localparam int B_CPHA = PW + 1;
  localparam int B_TXCL = PW + 2;
  localparam int B_RXCL = PW + 3;

  logic [PW-1:0] presc_q;
  logic          cpol_q, cpha_q, cs_n_q;

  logic          wr_ctrl, wr_data, rd_data;
  logic          clr_tx, clr_rx;
  logic [7:0]    tx_head, rx_head, eng_rx;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          eng_busy, eng_done, eng_phase, eng_start;

  assign wr_ctrl   = wr_en && (addr == ADDR_CTRL);
  assign wr_data   = wr_en && (addr == ADDR_DATA);
  assign rd_data   = rd_en && (addr == ADDR_DATA);
  assign clr_tx    = wr_ctrl && wdata[B_TXCL];
  assign clr_rx    = wr_ctrl && wdata[B_RXCL];
  assign eng_start = !cs_n_q && !eng_busy && !tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
    end else if (wr_ctrl) begin
      presc_q <= wdata[PW-1:0];
      cpol_q  <= wdata[B_CPOL];
      cpha_q  <= wdata[B_CPHA];
    end
  end

  // Select drops one cycle ahead of the first transfer, rises once idle and drained.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cs_n_q <= 1'b1;
    else if (cs_n_q && !tx_empty)                 cs_n_q <= 1'b0;
    else if (!cs_n_q && !eng_busy && tx_empty)    cs_n_q <= 1'b1;
  end

  spi_qm_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr_tx),
    .push(wr_data), .din(wdata[7:0]),
    .pop(eng_start), .dout(tx_head),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  spi_qm_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr_rx),
    .push(eng_done), .din(eng_rx),
    .pop(rd_data), .dout(rx_head),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  spi_qm_engine #(.PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .tx_byte(tx_head), .cpha(cpha_q), .presc(presc_q),
    .miso(miso), .busy(eng_busy), .done(eng_done),
    .rx_byte(eng_rx), .phase(eng_phase), .mosi(mosi)
  );

  assign sck  = cpol_q ^ eng_phase;
  assign cs_n = cs_n_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata = 16'({cpha_q, cpol_q, presc_q});
      ADDR_STAT: rdata = {sat_level(16'(rx_cnt)), sat_level(16'(tx_cnt))};
      ADDR_DATA: rdata = rx_empty ? 16'h0000 : {8'h00, rx_head};
      default:   rdata = '0;
    endcase
  end

  assert_sck_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cpol_q));

  assert_select_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !eng_busy);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_empty && !eng_done && !clr_rx) |=> rx_empty);

  assert_full_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_done && !rd_data && !clr_rx) |=> rx_full);

endmodule

// File: tb/sim_spi_qmaster.sv
`timescale 1ns/1ps
module sim_spi_qmaster;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wdata = '0;
  logic [15:0] rdata;
  logic        sck, mosi, cs_n, miso;

  always #2 clk = ~clk;

  spi_qmaster u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'h3C ^ 8'(i * 23);
  endfunction

  // ---------------- slave model ----------------
  logic       tb_cpol = 0, tb_cpha = 0;
  logic [7:0] sreg = 0, mrx = 0;
  logic [7:0] mlog [512];
  int         mn = 0, scnt = 0, sidx = 0, csf = 0, hp_bad = 0, ecnt_b = 0, last_t = 0;
  int         tb_presc = 0;
  logic       cs_prev = 1, sck_prev = 0;

  assign miso = sreg[7];

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (cs_prev && !cs_n) begin
      csf++;
      scnt = 0; ecnt_b = 0; last_t = cyc;
      if (!tb_cpha) begin sreg = pat(0); sidx = 1; end
      else sidx = 0;
    end else if (!cs_n && sck != sck_prev) begin
      if ((ecnt_b % 16) != 0 && (cyc - last_t) != tb_presc + 1) hp_bad++;
      last_t = cyc;
      ecnt_b++;
      if ((sck_prev == tb_cpol) ^ tb_cpha) begin
        mrx = {mrx[6:0], mosi};
        scnt++;
        if (scnt % 8 == 0) begin mlog[mn] = mrx; mn++; end
      end else begin
        if (scnt % 8 == 0) begin sreg = pat(sidx); sidx++; end
        else sreg = {sreg[6:0], 1'b0};
      end
    end
    cs_prev  = cs_n;
    sck_prev = sck;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // {cpha, cpol, prescaler, count, first byte}
  localparam logic [25:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd0, 8'd3, 8'h81},
    {1'b0, 1'b1, 8'd1, 8'd2, 8'h5A},
    {1'b1, 1'b0, 8'd2, 8'd3, 8'hC3},
    {1'b1, 1'b1, 8'd0, 8'd4, 8'h0F},
    {1'b1, 1'b1, 8'd5, 8'd1, 8'hE7},
    {1'b0, 1'b0, 8'd3, 8'd2, 8'h24}
  };

  initial begin
    logic [15:0] d;
    int bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    bus_rd(2'd0, d); check("R1 ctrl", d, 0);
    bus_rd(2'd1, d); check("R1 status", d, 0);
    // R5: empty read returns zero, nothing changes
    bus_rd(2'd2, d); check("R5 empty read", d, 0);
    bus_rd(2'd1, d); check("R5 status after empty read", d, 0);

    // R2/R8: field store, command bits not kept, idle level follows polarity
    tb_cpol = 1; tb_cpha = 1;
    bus_wr(2'd0, 12'h312);
    bus_rd(2'd0, d); check("R2 ctrl readback", d, 16'h0312);
    check("R8 sck idles at polarity 1", sck, 1);

    // Table of modes and rates
    foreach (VEC[v]) begin
      logic [7:0] pr, n, base;
      pr = VEC[v][23:16]; n = VEC[v][15:8]; base = VEC[v][7:0];
      tb_cpha = VEC[v][25]; tb_cpol = VEC[v][24]; tb_presc = int'(pr);
      bus_wr(2'd0, {2'b00, VEC[v][25:24], pr});
      repeat (2) @(negedge clk);
      check("R8 idle level", sck, VEC[v][24]);
      mn = 0; csf = 0; hp_bad = 0;
      for (int i = 0; i < int'(n); i++) bus_wr(2'd2, {4'h0, 8'(base + i * 17)});
      wait_idle();
      check("R9 one select fall per burst", csf, 1);
      check("R6 half period", hp_bad, 0);
      check("R7 byte count on mosi", mn, n);
      for (int i = 0; i < int'(n); i++)
        check("R7 mosi byte MSB first", mlog[i], 8'(base + i * 17));
      bus_rd(2'd1, d); check("R3 status levels", d, {n, 8'h00});
      for (int i = 0; i < int'(n); i++) begin
        bus_rd(2'd2, d); check("R7 captured miso byte", d, {8'h00, pat(i)});
      end
      check("R8 sck rests with select high", sck, VEC[v][24]);
    end

    // R4/R3/R11: overflow both queues (prescaler 7, mode 0)
    tb_cpol = 0; tb_cpha = 0; tb_presc = 7;
    bus_wr(2'd0, 12'h007);
    mn = 0; csf = 0; hp_bad = 0;
    for (int i = 0; i < 260; i++) bus_wr(2'd2, {4'h0, 8'(i)});
    bus_rd(2'd1, d); check("R3 tx level saturates", d[7:0], 8'hFF);
    wait_idle();
    check("R4 drops when full", mn, 258);
    check("R4 last accepted byte", mlog[257], 8'h01);
    check("R6 half period long burst", hp_bad, 0);
    bus_rd(2'd1, d); check("R11 rx level saturates", d, 16'hFF00);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      bus_rd(2'd2, d);
      if (d !== {8'h00, pat(i)}) bad++;
    end
    check("R11 oldest 256 kept", bad, 0);
    bus_rd(2'd2, d); check("R5 drained read zero", d, 0);
    bus_rd(2'd1, d); check("R5 status empty", d, 0);

    // R10: flush transmit queue mid-transfer
    tb_presc = 255;
    bus_wr(2'd0, 12'h0FF);
    mn = 0;
    for (int i = 0; i < 3; i++) bus_wr(2'd2, 12'h0A0 + 12'(i));
    repeat (20) @(negedge clk);
    bus_wr(2'd0, 12'h4FF);
    bus_rd(2'd1, d); check("R10 tx flushed", d[7:0], 0);
    check("R10 select held during byte", cs_n, 0);
    wait_idle();
    check("R10 in-flight byte completes", mn, 1);
    bus_rd(2'd1, d); check("R10 rx untouched by tx flush", d, 16'h0100);
    bus_wr(2'd0, 12'h8FF);
    bus_rd(2'd1, d); check("R10 rx flushed", d, 0);
    bus_rd(2'd0, d); check("R2 command bits not stored", d, 16'h00FF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule